// File: doc/BRIEF.md
# Asynchronous Device Access Sequencer

This block runs one access to an asynchronous device, such as an SRAM, a NOR flash or a simple peripheral, once the surrounding bus logic has picked the bank. It takes a request that carries an address, write data, two byte enables, a direction bit and a programmed strobe length. It then drives chip select, a read strobe and two write strobes, one for each byte lane of a 16-bit port, through a fixed sequence. That sequence is address setup, strobe active, hold, and then a one-cycle completion pulse.

The device can end the strobe early by raising an acknowledge input. A bus monitor counts the clocks of the access. When a non-zero limit is exceeded, it aborts the cycle, negates every strobe and reports an error instead of completion. The setup cycle and the hold cycle always bracket at least one strobe cycle, so chip select stays active for at least three clocks.

Top module: `gpcs_access`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dev_cs_n`, `dev_oe_n` and both bits of `dev_we_n` are 1, and `rsp_done`, `rsp_err` and `busy` are 0. An asserted reset in the middle of an access returns all strobes to 1 in the same cycle.
- R2: A request seen with `req_valid`=1 while idle starts an access in the next cycle. That first cycle is a setup cycle, with `dev_cs_n`=0, `dev_oe_n`=1, both `dev_we_n` bits 1 and `dev_addr` equal to the captured address.
- R3: Without an acknowledge or a timeout, the strobe phase lasts `req_wait` cycles, or one cycle when `req_wait` is 0.
- R4: After the last strobe cycle there is exactly one hold cycle, with chip select still 0 and all strobes 1. In the cycle after that, `rsp_done`=1 for exactly one cycle with chip select 1, and then the block is idle (`busy`=0).
- R5: A completed access keeps `dev_cs_n` at 0 for at least three cycles, including when `req_wait` is 0.
- R6: A read holds `dev_oe_n` at 0 in every strobe cycle, with both `dev_we_n` bits at 1. `rsp_rdata` takes the value of `dev_din` present in the last strobe cycle.
- R7: A write holds `dev_oe_n` at 1. In every strobe cycle, `dev_we_n[i]` is 0 exactly when `req_be[i]` was 1, where bit 0 is the lane carrying data bits 7:0. While chip select is 0, `dev_dout` equals the write data and `dev_dout_en` is 1.
- R8: `ext_ack`=1 during a strobe cycle makes that cycle the last strobe cycle. `ext_ack` has no effect during the setup, hold or idle cycles.
- R9: With `bmon_limit`=L>0, an access that would keep chip select 0 for more than L cycles is cut off. Chip select stays 0 for L+1 cycles. In the next cycle, all strobes and chip select are 1 and `rsp_err`=1 for one cycle. `rsp_done` stays 0, and the block is then idle.
- R10: `bmon_limit`=0 disables the monitor, so even the longest strobe length completes with `rsp_done` and no error.
- R11: `req_valid` is ignored while `busy`=1. The running access keeps its direction, length and strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Device address |
| req_wdata | input | 8*LANES | Write data |
| req_be | input | LANES | Byte-lane enables for writes |
| req_wait | input | WAIT_W | Strobe length in cycles (0 acts as 1) |
| bmon_limit | input | TMO_W | Bus-monitor limit in cycles, 0 = off |
| ext_ack | input | 1 | Device acknowledge, ends the strobe phase |
| dev_din | input | 8*LANES | Data from device |
| dev_cs_n | output | 1 | Chip select, active low |
| dev_oe_n | output | 1 | Output enable (read strobe), active low |
| dev_we_n | output | LANES | Per-lane write enables, active low |
| dev_addr | output | ADDR_W | Address to device |
| dev_dout | output | 8*LANES | Write data to device |
| dev_dout_en | output | 1 | Drive enable for `dev_dout` |
| rsp_rdata | output | 8*LANES | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle bus-monitor abort pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the block with its defaults: a 4-bit wait count, an 8-bit monitor limit and two byte lanes. The largest strobe length, 15, therefore fits in a short run next to a zero limit. Small limits of 1, 4, 5 and 6 can then fall in the setup cycle, in the strobe phase, in the hold cycle, or exactly on the boundary where the access still completes. Acknowledge placement at the first, middle and outside-strobe cycles becomes reachable with the same short strobe counts.

// File: rtl/gpcs_pkg.sv
package gpcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DONE   = 3'd4,
        ST_ABORT  = 3'd5
    } gpcs_state_e;

    function automatic logic is_active(gpcs_state_e s);
        return (s == ST_SETUP) || (s == ST_STROBE) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/gpcs_wait_ctr.sv
module gpcs_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    input  logic              dec_i,
    output logic              last_o
);

    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (load_val_i == '0) ? ONE : load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q <= ONE);

endmodule

// File: rtl/gpcs_busmon.sv
module gpcs_busmon #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expire_o
);

    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (active_i) begin
            cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + TMO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = active_i && (limit_i != '0) && (cnt_q >= limit_i);

endmodule

// File: rtl/gpcs_access.sv
module gpcs_access
    import gpcs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANES  = 2,
    parameter int WAIT_W = 4,
    parameter int TMO_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [8*LANES-1:0]   req_wdata,
    input  logic [LANES-1:0]     req_be,
    input  logic [WAIT_W-1:0]    req_wait,
    input  logic [TMO_W-1:0]     bmon_limit,
    input  logic                 ext_ack,
    input  logic [8*LANES-1:0]   dev_din,
    output logic                 dev_cs_n,
    output logic                 dev_oe_n,
    output logic [LANES-1:0]     dev_we_n,
    output logic [ADDR_W-1:0]    dev_addr,
    output logic [8*LANES-1:0]   dev_dout,
    output logic                 dev_dout_en,
    output logic [8*LANES-1:0]   rsp_rdata,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic                 busy
);

    localparam int DATA_W = 8 * LANES;

    typedef struct packed {
        gpcs_state_e        st;
        logic               wr;
        logic [LANES-1:0]   be;
        logic [WAIT_W-1:0]  wt;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic wait_load, wait_dec, wait_last;
    logic active, expire;

    assign active = is_active(r_q.st);

    gpcs_wait_ctr #(.WAIT_W(WAIT_W)) i_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wait_load),
        .load_val_i (r_q.wt),
        .dec_i      (wait_dec),
        .last_o     (wait_last)
    );

    gpcs_busmon #(.TMO_W(TMO_W)) i_bmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .limit_i  (bmon_limit),
        .expire_o (expire)
    );

    always_comb begin
        r_d       = r_q;
        wait_load = 1'b0;
        wait_dec  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_SETUP;
                    r_d.wr    = req_write;
                    r_d.be    = req_be;
                    r_d.wt    = req_wait;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                end
            end
            ST_SETUP: begin
                wait_load = 1'b1;
                r_d.st    = ST_STROBE;
            end
            ST_STROBE: begin
                wait_dec = 1'b1;
                if (wait_last || ext_ack) begin
                    r_d.st = ST_HOLD;
                    if (!r_q.wr) r_d.rdata = dev_din;
                end
            end
            ST_HOLD:  r_d.st = ST_DONE;
            ST_DONE:  r_d.st = ST_IDLE;
            ST_ABORT: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
        if (expire) begin
            r_d.st    = ST_ABORT;
            r_d.rdata = r_q.rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    logic strobe_on;
    assign strobe_on = (r_q.st == ST_STROBE);

    assign dev_cs_n    = !active;
    assign dev_oe_n    = !(strobe_on && !r_q.wr);
    assign dev_addr    = r_q.addr;
    assign dev_dout    = r_q.wdata;
    assign dev_dout_en = active && r_q.wr;
    assign rsp_rdata   = r_q.rdata;
    assign rsp_done    = (r_q.st == ST_DONE);
    assign rsp_err     = (r_q.st == ST_ABORT);
    assign busy        = (r_q.st != ST_IDLE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dev_we_n[g] = !(strobe_on && r_q.wr && r_q.be[g]);
    end

endmodule

// File: rtl/gpcs_access_chk.sv
module gpcs_access_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev_cs_n,
    input logic             dev_oe_n,
    input logic [LANES-1:0] dev_we_n,
    input logic             rsp_done,
    input logic             rsp_err,
    input logic             busy
);

    logic any_strobe;
    assign any_strobe = !dev_oe_n || (dev_we_n != '1);

    // R2: a strobe is only ever active under chip select
    a_r2_strobe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> !dev_cs_n);

    // R6: read and write strobes never overlap
    a_r6_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n |-> (dev_we_n == '1));

    // R4: completion is a single-cycle pulse with chip select released
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r4_done_cs_off: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (dev_cs_n && busy));

    // R9: abort has all strobes negated and lasts one cycle, never with done
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (dev_cs_n && dev_oe_n && dev_we_n == '1 && !rsp_done));
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err);

    // R5: chip select, once asserted, holds a second cycle unless aborted
    a_r5_cs_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_cs_n) |=> (!dev_cs_n || rsp_err));

    // R2: chip select is never asserted while idle
    a_r2_cs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_cs_n |-> busy);

endmodule

bind gpcs_access gpcs_access_chk #(.LANES(LANES)) i_gpcs_access_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_cs_n (dev_cs_n),
    .dev_oe_n (dev_oe_n),
    .dev_we_n (dev_we_n),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .busy     (busy)
);

// File: tb/test_gpcs_access.sv
module test_gpcs_access;

    localparam int ADDR_W = 24;
    localparam int LANES  = 2;
    localparam int WAIT_W = 4;
    localparam int TMO_W  = 8;
    localparam int DW     = 8 * LANES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic [LANES-1:0]  req_be = '0;
    logic [WAIT_W-1:0] req_wait = '0;
    logic [TMO_W-1:0]  bmon_limit = '0;
    logic              ext_ack = 1'b0;
    logic [DW-1:0]     dev_din = '0;
    logic              dev_cs_n, dev_oe_n, dev_dout_en, rsp_done, rsp_err, busy;
    logic [LANES-1:0]  dev_we_n;
    logic [ADDR_W-1:0] dev_addr;
    logic [DW-1:0]     dev_dout, rsp_rdata;

    gpcs_access #(.ADDR_W(ADDR_W), .LANES(LANES), .WAIT_W(WAIT_W), .TMO_W(TMO_W)) i_gpcs_access (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_wait(req_wait),
        .bmon_limit(bmon_limit), .ext_ack(ext_ack), .dev_din(dev_din),
        .dev_cs_n(dev_cs_n), .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n), .dev_addr(dev_addr),
        .dev_dout(dev_dout), .dev_dout_en(dev_dout_en), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .busy(busy)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    typedef struct packed {
        logic        wr;
        logic [3:0]  wt;
        logic [1:0]  be;
        logic [7:0]  lim;
        logic [3:0]  ack;
        logic        junk;
        logic        spam;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd3,  2'b11, 8'd0, 4'd0, 1'b0, 1'b0, 16'hA5C3},  // R3 R6
        '{1'b0, 4'd0,  2'b11, 8'd0, 4'd0, 1'b0, 1'b0, 16'h1234},  // R5
        '{1'b1, 4'd2,  2'b01, 8'd0, 4'd0, 1'b0, 1'b0, 16'h00FE},  // R7 lane 0
        '{1'b1, 4'd4,  2'b10, 8'd0, 4'd0, 1'b0, 1'b0, 16'hBE00},  // R7 lane 1
        '{1'b1, 4'd1,  2'b11, 8'd0, 4'd0, 1'b0, 1'b0, 16'h5A5A},  // R7 both
        '{1'b0, 4'd8,  2'b11, 8'd0, 4'd3, 1'b0, 1'b0, 16'h0F0F},  // R8 mid
        '{1'b0, 4'd5,  2'b11, 8'd0, 4'd1, 1'b1, 1'b0, 16'h7E81},  // R8 first
        '{1'b0, 4'd2,  2'b11, 8'd0, 4'd0, 1'b1, 1'b0, 16'hC33C},  // R8 ignored
        '{1'b0, 4'd10, 2'b11, 8'd6, 4'd0, 1'b0, 1'b0, 16'h9999},  // R9 strobe
        '{1'b1, 4'd15, 2'b11, 8'd0, 4'd0, 1'b0, 1'b0, 16'h4242},  // R10
        '{1'b1, 4'd3,  2'b11, 8'd5, 4'd0, 1'b0, 1'b0, 16'h6161},  // R9 boundary
        '{1'b0, 4'd3,  2'b11, 8'd4, 4'd0, 1'b0, 1'b0, 16'h2468},  // R9 hold
        '{1'b0, 4'd2,  2'b11, 8'd1, 4'd0, 1'b0, 1'b1, 16'h1357},  // R9 + R11
        '{1'b1, 4'd2,  2'b11, 8'd0, 4'd0, 1'b0, 1'b1, 16'hF00D}   // R11
    };

    task automatic run_vec(input vec_t v);
        int ws, s_exp, cs_exp, st_exp;
        bit err_exp;
        int cs_cnt, st_cnt, done_cnt, err_cnt, n;
        bit strobe_bad, dout_bad, addr_bad, ended;
        logic [ADDR_W-1:0] a;
        ws      = (v.wt == 0) ? 1 : int'(v.wt);
        s_exp   = (v.ack != 0 && int'(v.ack) <= ws) ? int'(v.ack) : ws;
        err_exp = (v.lim != 0) && (s_exp + 2 > int'(v.lim));
        cs_exp  = err_exp ? int'(v.lim) + 1 : s_exp + 2;
        st_exp  = err_exp ? ((s_exp < int'(v.lim)) ? s_exp : int'(v.lim)) : s_exp;
        a       = {8'h3C, v.data};
        cs_cnt = 0; st_cnt = 0; done_cnt = 0; err_cnt = 0;
        strobe_bad = 0; dout_bad = 0; addr_bad = 0; ended = 0;

        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = v.wr;
        req_addr   = a;
        req_wdata  = v.data;
        req_be     = v.be;
        req_wait   = v.wt;
        bmon_limit = v.lim;
        dev_din    = ~v.data;
        n = 0;
        while (!ended && n < 100) begin
            @(negedge clk);
            n++;
            req_valid = (v.spam && busy);
            req_write = v.spam ? ~v.wr : v.wr;
            req_wait  = v.spam ? 4'd1 : v.wt;
            if (!dev_cs_n) begin
                cs_cnt++;
                if (dev_addr != a) addr_bad = 1;
                if (v.wr && (dev_dout != v.data || !dev_dout_en)) dout_bad = 1;
            end
            if (!dev_oe_n || dev_we_n != 2'b11) begin
                st_cnt++;
                if (!v.wr && !(dev_oe_n == 1'b0 && dev_we_n == 2'b11)) strobe_bad = 1;
                if (v.wr && !(dev_oe_n == 1'b1 && dev_we_n == ~v.be)) strobe_bad = 1;
                ext_ack = (v.ack != 0 && st_cnt == int'(v.ack));
                dev_din = (st_cnt == s_exp) ? v.data : ~v.data;
            end else begin
                ext_ack = v.junk && !dev_cs_n;
                dev_din = ~v.data;
            end
            if (rsp_done) done_cnt++;
            if (rsp_err)  err_cnt++;
            if (rsp_done || rsp_err) ended = 1;
        end
        req_valid = 1'b0;
        ext_ack   = 1'b0;
        @(negedge clk);
        if (rsp_done) done_cnt++;
        if (rsp_err)  err_cnt++;

        check(cs_cnt == cs_exp, err_exp ? "R9 cs cycles" : "R3/R5 cs cycles", cs_cnt, cs_exp);
        check(st_cnt == st_exp, v.ack != 0 ? "R8 strobe cycles" : "R3 strobe cycles", st_cnt, st_exp);
        check(!strobe_bad, v.wr ? "R7 write strobes" : "R6 read strobe", strobe_bad, 0);
        check(!addr_bad, "R2 address", addr_bad, 0);
        check(done_cnt == (err_exp ? 0 : 1), "R4 done pulse", done_cnt, err_exp ? 0 : 1);
        check(err_cnt == (err_exp ? 1 : 0), err_exp ? "R9 error pulse" : "R10 no error", err_cnt, err_exp ? 1 : 0);
        check(!busy && dev_cs_n, "R4 back to idle", busy, 0);
        if (v.wr)
            check(!dout_bad, "R7 write data", dout_bad, 0);
        else if (!err_exp)
            check(rsp_rdata == v.data, "R6 read data", int'(rsp_rdata), int'(v.data));
        if (v.spam) begin
            repeat (3) begin
                @(negedge clk);
                check(dev_cs_n && !busy, "R11 request ignored while busy", busy, 0);
            end
        end
    endtask

    initial begin
        // R1: reset state
        #5;
        check(dev_cs_n && dev_oe_n && dev_we_n == 2'b11, "R1 strobes in reset", dev_cs_n, 1);
        check(!rsp_done && !rsp_err && !busy, "R1 flags in reset", busy, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dev_cs_n && !busy && !rsp_done && !rsp_err, "R1 after reset", busy, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset in the middle of a write strobe
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_be = 2'b11; req_wait = 4'd6; bmon_limit = '0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(dev_we_n == 2'b00, "R7 strobe before reset", dev_we_n, 0);
        rst_n = 1'b0;
        #1;
        check(dev_cs_n && dev_we_n == 2'b11 && !busy, "R1 reset mid access", dev_we_n, 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dev_cs_n && !busy, "R1 idle after reset", busy, 0);

        finish_run();
    end

endmodule